// File: doc/BRIEF.md
# Reorder Buffer with Per-Class Oldest-First Dispatch

This block is a circular window of in-flight instructions. They enter at the head pointer and leave from the tail pointer in program order. Each slot records the operation code, the architectural and physical destinations, and two source operands. Each operand has a tag, a ready flag and a 16-bit value. Each slot also holds a 16-bit field that starts as the immediate and is later replaced by the result. Two flags complete the slot: dispatched, and complete.

Every occupied slot watches three writeback buses. A source whose tag matches a bus takes the bus value and becomes ready. A slot whose physical destination matches a bus stores the result and becomes complete. A writeback can land in the same cycle that a dependent instruction is written. To keep such a wakeup from being lost, each operand that arrives not ready is looked up once more in the cycle after it is written. That lookup searches the buffer for a completed producer with the same tag.

Three independent selectors each offer one slot per cycle on a valid/ready port. The branch port offers the oldest undispatched branch. The memory port offers the oldest undispatched load or store. The register-operation port offers the oldest undispatched other instruction whose two operands are both ready. A completed slot at the tail is handed to the register file and freed.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, and `dp_vld` and `rt_vld` are 0.
- R2: The buffer holds at most DEPTH-1 instructions. It is full when head+1 equals tail. While full, `iss_ready` is 0 and an `iss_valid` request writes nothing.
- R3: Port 0 (branch) offers the undispatched occupied slot with opcode 0x10 that is nearest the tail. Its operand readiness is not considered.
- R4: Port 1 (memory) offers the undispatched occupied slot with opcode 0x08 (load) or 0x09 (store) that is nearest the tail.
- R5: Port 2 (register op) offers the undispatched occupied slot nearest the tail whose opcode is none of 0x10, 0x08 or 0x09 and whose two sources are both ready.
- R6: A slot is marked dispatched only in a cycle where its port has `dp_vld` and `dp_rdy` both high. Until then the same slot stays on offer.
- R7: A not-ready source whose tag equals the tag of a valid writeback bus takes that bus's data and becomes ready. When several buses carry the tag, the lowest-numbered bus wins.
- R8: A slot that is not yet complete, and whose physical destination equals a valid writeback tag, stores that data as its result and becomes complete.
- R9: In the cycle after a slot is written, each of its not-ready sources is compared against the other occupied complete slots. On a match of physical destination, that slot's result is copied in and the source becomes ready.
- R10: When the tail slot is occupied and complete, `rt_vld` is 1 and the tail advances by one that cycle. The port shows the slot's architectural destination, physical destination and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | New instruction offered |
| iss_ready | output | 1 | Buffer not full |
| iss_op | input | 5 | Operation code |
| iss_adst | input | AW | Architectural destination |
| iss_pdst | input | PW | Physical destination tag |
| iss_src1 | input | PW | Source 1 tag |
| iss_src1_rdy | input | 1 | Source 1 ready at issue |
| iss_src1_val | input | DW | Source 1 value |
| iss_src2 | input | PW | Source 2 tag |
| iss_src2_rdy | input | 1 | Source 2 ready at issue |
| iss_src2_val | input | DW | Source 2 value |
| iss_imm | input | DW | Immediate |
| wb_vld | input | 3 | Writeback bus valids |
| wb_tag | input | 3*PW | Writeback tags, bus b at [b*PW +: PW] |
| wb_data | input | 3*DW | Writeback data, bus b at [b*DW +: DW] |
| dp_vld | output | 3 | Offer valid per port (0 branch, 1 memory, 2 register op) |
| dp_rdy | input | 3 | Port accepts |
| dp_idx | output | 3*IW | Offered slot index per port |
| dp_op | output | 15 | Offered opcode per port |
| dp_pdst | output | 3*PW | Offered physical destination per port |
| dp_opa | output | 3*DW | Offered source 1 value per port |
| dp_opb | output | 3*DW | Offered source 2 value per port |
| dp_imm | output | 3*DW | Offered immediate per port |
| rt_vld | output | 1 | Retirement this cycle |
| rt_adst | output | AW | Retiring architectural destination |
| rt_pdst | output | PW | Retiring physical destination |
| rt_data | output | DW | Retiring result |

## Verification
The first phase issues instructions back to back with every port stalled and no writebacks. This shows that the buffer stops at DEPTH-1 slots and that a refused issue leaves the state alone.

A long mixed phase follows, with random opcodes, random port acceptance and random writebacks to dispatched slots. It separates oldest-first selection across wrapped pointers from selection that merely looks plausible. It also shows whether a stalled offer is held.

The generator deliberately issues consumers whose producer is written back in the same cycle. Only the post-write lookup rescues those operands. It also occasionally sends one tag on two buses with different data, which exposes the bus priority.

A final drain phase with all ports open checks in-order retirement down to empty.

// File: rtl/rob_pkg.sv
package rob_pkg;
   localparam int OPW    = 5;
   localparam int NWB    = 3;
   localparam int NPORT  = 3;
   localparam int PORT_BR  = 0;
   localparam int PORT_MEM = 1;
   localparam int PORT_REG = 2;
   localparam logic [OPW-1:0] OPC_BRZ   = 5'h10;
   localparam logic [OPW-1:0] OPC_LOAD  = 5'h08;
   localparam logic [OPW-1:0] OPC_STORE = 5'h09;
endpackage

// File: rtl/rob_cam.sv
module rob_cam #(
   parameter int NB = 3,
   parameter int PW = 5,
   parameter int DW = 16
) (
   input  logic [PW-1:0]    tag,
   input  logic [NB-1:0]    bus_vld,
   input  logic [NB*PW-1:0] bus_tag,
   input  logic [NB*DW-1:0] bus_data,
   output logic             hit,
   output logic [DW-1:0]    data
);
   // lowest-numbered bus has priority: scanned last
   always_comb begin
      hit  = 1'b0;
      data = '0;
      for (int b = NB - 1; b >= 0; b--) begin
         if (bus_vld[b] && (bus_tag[b*PW +: PW] == tag)) begin
            hit  = 1'b1;
            data = bus_data[b*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic [DEPTH-1:0] cand,
   input  logic [IW-1:0]    tail,
   output logic             hit,
   output logic [IW-1:0]    idx
);
   // scanned youngest to oldest so the oldest candidate is written last
   always_comb begin
      hit = 1'b0;
      idx = tail;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (cand[IW'(tail + IW'(k))]) begin
            hit = 1'b1;
            idx = IW'(tail + IW'(k));
         end
      end
   end
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   parameter int PW    = 5,
   parameter int AW    = 4,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  iss_valid,
   output logic                  iss_ready,
   input  logic [OPW-1:0]        iss_op,
   input  logic [AW-1:0]         iss_adst,
   input  logic [PW-1:0]         iss_pdst,
   input  logic [PW-1:0]         iss_src1,
   input  logic                  iss_src1_rdy,
   input  logic [DW-1:0]         iss_src1_val,
   input  logic [PW-1:0]         iss_src2,
   input  logic                  iss_src2_rdy,
   input  logic [DW-1:0]         iss_src2_val,
   input  logic [DW-1:0]         iss_imm,
   input  logic [NWB-1:0]        wb_vld,
   input  logic [NWB*PW-1:0]     wb_tag,
   input  logic [NWB*DW-1:0]     wb_data,
   output logic [NPORT-1:0]      dp_vld,
   input  logic [NPORT-1:0]      dp_rdy,
   output logic [NPORT*IW-1:0]   dp_idx,
   output logic [NPORT*OPW-1:0]  dp_op,
   output logic [NPORT*PW-1:0]   dp_pdst,
   output logic [NPORT*DW-1:0]   dp_opa,
   output logic [NPORT*DW-1:0]   dp_opb,
   output logic [NPORT*DW-1:0]   dp_imm,
   output logic                  rt_vld,
   output logic [AW-1:0]         rt_adst,
   output logic [PW-1:0]         rt_pdst,
   output logic [DW-1:0]         rt_data
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("rob_core: DEPTH must be a power of two, at least 2, with IW = log2(DEPTH)");
   end
   if (DW < 1 || PW < 1 || AW < 1) begin : g_bad_width
      $error("rob_core: data, tag and register widths must be positive");
   end

   // slot storage
   logic [OPW-1:0] e_op   [DEPTH];
   logic [AW-1:0]  e_adst [DEPTH];
   logic [PW-1:0]  e_pdst [DEPTH];
   logic [PW-1:0]  e_src1 [DEPTH];
   logic [PW-1:0]  e_src2 [DEPTH];
   logic [DW-1:0]  e_v1   [DEPTH];
   logic [DW-1:0]  e_v2   [DEPTH];
   logic [DW-1:0]  e_imm  [DEPTH];
   logic [DEPTH-1:0] e_r1, e_r2, e_disp, e_done;

   logic [IW-1:0] head, tail, used, pidx;
   logic          pend, full;
   logic [DEPTH-1:0] occ, is_br, is_mem;

   assign used      = head - tail;
   assign full      = (head + IW'(1)) == tail;
   assign iss_ready = ~full;

   // writeback match per slot
   logic [DEPTH-1:0]         h1, h2, hd;
   logic [DEPTH-1:0][DW-1:0] d1, d2, dd;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign occ[i]    = (IW'(i) - tail) < used;
      assign is_br[i]  = e_op[i] == OPC_BRZ;
      assign is_mem[i] = (e_op[i] == OPC_LOAD) || (e_op[i] == OPC_STORE);

      rob_cam #(.NB(NWB), .PW(PW), .DW(DW)) u_cam1 (
         .tag(e_src1[i]), .bus_vld(wb_vld), .bus_tag(wb_tag), .bus_data(wb_data),
         .hit(h1[i]), .data(d1[i]));
      rob_cam #(.NB(NWB), .PW(PW), .DW(DW)) u_cam2 (
         .tag(e_src2[i]), .bus_vld(wb_vld), .bus_tag(wb_tag), .bus_data(wb_data),
         .hit(h2[i]), .data(d2[i]));
      rob_cam #(.NB(NWB), .PW(PW), .DW(DW)) u_camd (
         .tag(e_pdst[i]), .bus_vld(wb_vld), .bus_tag(wb_tag), .bus_data(wb_data),
         .hit(hd[i]), .data(dd[i]));
   end

   // second readiness look-up for the slot written last cycle
   logic          rc1_hit, rc2_hit;
   logic [DW-1:0] rc1_val, rc2_val;
   always_comb begin
      rc1_hit = 1'b0;
      rc2_hit = 1'b0;
      rc1_val = '0;
      rc2_val = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (occ[j] && e_done[j] && (IW'(j) != pidx)) begin
            if (e_pdst[j] == e_src1[pidx]) begin
               rc1_hit = 1'b1;
               rc1_val = e_imm[j];
            end
            if (e_pdst[j] == e_src2[pidx]) begin
               rc2_hit = 1'b1;
               rc2_val = e_imm[j];
            end
         end
      end
   end

   // per-class selectors
   logic [NPORT-1:0][IW-1:0] sel;
   logic [NPORT-1:0]         acc;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [DEPTH-1:0] cand;
      if (p == PORT_BR) begin : g_br
         assign cand = occ & ~e_disp & is_br;
      end else if (p == PORT_MEM) begin : g_mem
         assign cand = occ & ~e_disp & is_mem;
      end else begin : g_reg
         assign cand = occ & ~e_disp & ~is_br & ~is_mem & e_r1 & e_r2;
      end

      rob_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
         .cand(cand), .tail(tail), .hit(dp_vld[p]), .idx(sel[p]));

      assign acc[p]                 = dp_vld[p] & dp_rdy[p];
      assign dp_idx[p*IW +: IW]     = sel[p];
      assign dp_op[p*OPW +: OPW]    = e_op[sel[p]];
      assign dp_pdst[p*PW +: PW]    = e_pdst[sel[p]];
      assign dp_opa[p*DW +: DW]     = e_v1[sel[p]];
      assign dp_opb[p*DW +: DW]     = e_v2[sel[p]];
      assign dp_imm[p*DW +: DW]     = e_imm[sel[p]];
   end

   assign rt_vld  = (used != '0) && e_done[tail];
   assign rt_adst = e_adst[tail];
   assign rt_pdst = e_pdst[tail];
   assign rt_data = e_imm[tail];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head   <= '0;
         tail   <= '0;
         pend   <= 1'b0;
         pidx   <= '0;
         e_r1   <= '0;
         e_r2   <= '0;
         e_disp <= '0;
         e_done <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (occ[i]) begin
               if (!e_r1[i] && h1[i]) begin
                  e_v1[i] <= d1[i];
                  e_r1[i] <= 1'b1;
               end else if (!e_r1[i] && pend && (pidx == IW'(i)) && rc1_hit) begin
                  e_v1[i] <= rc1_val;
                  e_r1[i] <= 1'b1;
               end
               if (!e_r2[i] && h2[i]) begin
                  e_v2[i] <= d2[i];
                  e_r2[i] <= 1'b1;
               end else if (!e_r2[i] && pend && (pidx == IW'(i)) && rc2_hit) begin
                  e_v2[i] <= rc2_val;
                  e_r2[i] <= 1'b1;
               end
               if (!e_done[i] && hd[i]) begin
                  e_imm[i]  <= dd[i];
                  e_done[i] <= 1'b1;
               end
            end
         end
         for (int p = 0; p < NPORT; p++) begin
            if (acc[p]) e_disp[sel[p]] <= 1'b1;
         end
         if (rt_vld) tail <= tail + IW'(1);
         if (iss_valid && !full) begin
            e_op[head]   <= iss_op;
            e_adst[head] <= iss_adst;
            e_pdst[head] <= iss_pdst;
            e_src1[head] <= iss_src1;
            e_src2[head] <= iss_src2;
            e_r1[head]   <= iss_src1_rdy;
            e_r2[head]   <= iss_src2_rdy;
            e_v1[head]   <= iss_src1_val;
            e_v2[head]   <= iss_src2_val;
            e_imm[head]  <= iss_imm;
            e_disp[head] <= 1'b0;
            e_done[head] <= 1'b0;
            head         <= head + IW'(1);
            pend         <= 1'b1;
            pidx         <= head;
         end else begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
   import rob_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           iss_valid,
   input logic           iss_ready,
   input logic           rt_vld,
   input logic           br_vld,
   input logic           br_rdy,
   input logic [IW-1:0]  br_idx,
   input logic [OPW-1:0] br_op,
   input logic [IW-1:0]  head,
   input logic [IW-1:0]  tail
);
   // R2
   full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_ready && !rt_vld) |=> !iss_ready);

   // R2
   issue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> (head == IW'($past(head) + IW'(1))));

   // R10
   retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rt_vld |=> (tail == IW'($past(tail) + IW'(1))));

   // R10
   empty_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head == tail) |-> !rt_vld);

   // R3
   branch_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_vld |-> (br_op == OPC_BRZ));

   // R6
   branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_vld && !br_rdy) |=> (br_vld && (br_idx == $past(br_idx))));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .IW(IW)) u_rob_core_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
   .rt_vld(rt_vld), .br_vld(dp_vld[0]), .br_rdy(dp_rdy[0]),
   .br_idx(dp_idx[IW-1:0]), .br_op(dp_op[rob_pkg::OPW-1:0]),
   .head(head), .tail(tail));

// File: tb/rob_core_bench.sv
module rob_core_bench;
   import rob_pkg::*;
   localparam int D  = 8;
   localparam int DW = 16;
   localparam int PW = 5;
   localparam int AW = 4;
   localparam int IW = 3;
   localparam int NP = 3;

   // one time unit is taken as 1 ns: 10 ns period, 100 MHz
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              iss_valid, iss_ready, iss_src1_rdy, iss_src2_rdy;
   logic [OPW-1:0]    iss_op;
   logic [AW-1:0]     iss_adst;
   logic [PW-1:0]     iss_pdst, iss_src1, iss_src2;
   logic [DW-1:0]     iss_src1_val, iss_src2_val, iss_imm;
   logic [NWB-1:0]    wb_vld;
   logic [NWB*PW-1:0] wb_tag;
   logic [NWB*DW-1:0] wb_data;
   logic [NP-1:0]     dp_vld, dp_rdy;
   logic [NP*IW-1:0]  dp_idx;
   logic [NP*OPW-1:0] dp_op;
   logic [NP*PW-1:0]  dp_pdst;
   logic [NP*DW-1:0]  dp_opa, dp_opb, dp_imm;
   logic              rt_vld;
   logic [AW-1:0]     rt_adst;
   logic [PW-1:0]     rt_pdst;
   logic [DW-1:0]     rt_data;

   rob_core #(.DEPTH(D), .DW(DW), .PW(PW), .AW(AW), .IW(IW)) u_rob_core (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_adst(iss_adst), .iss_pdst(iss_pdst),
      .iss_src1(iss_src1), .iss_src1_rdy(iss_src1_rdy), .iss_src1_val(iss_src1_val),
      .iss_src2(iss_src2), .iss_src2_rdy(iss_src2_rdy), .iss_src2_val(iss_src2_val),
      .iss_imm(iss_imm), .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
      .dp_vld(dp_vld), .dp_rdy(dp_rdy), .dp_idx(dp_idx), .dp_op(dp_op),
      .dp_pdst(dp_pdst), .dp_opa(dp_opa), .dp_opb(dp_opb), .dp_imm(dp_imm),
      .rt_vld(rt_vld), .rt_adst(rt_adst), .rt_pdst(rt_pdst), .rt_data(rt_data));

   // behavioural reference
   int m_op[D], m_adst[D], m_pdst[D], m_s1[D], m_s2[D], m_v1[D], m_v2[D], m_imm[D];
   bit m_r1[D], m_r2[D], m_disp[D], m_done[D];
   int m_head, m_tail, m_pidx;
   bit m_pend;
   int n_vec = 0, n_bad = 0, seq = 0;
   bit finished = 0;

   function automatic int m_count();
      return (m_head - m_tail + D) % D;
   endfunction
   function automatic bit m_occ(int i);
      return ((i - m_tail + D) % D) < m_count();
   endfunction
   function automatic bit m_full();
      return m_count() == D - 1;
   endfunction
   function automatic bit in_class(int p, int i);
      bit br  = (m_op[i] == 16);
      bit mem = (m_op[i] == 8) || (m_op[i] == 9);
      if (p == 0) return br;
      if (p == 1) return mem;
      return !br && !mem && m_r1[i] && m_r2[i];
   endfunction
   function automatic int m_pick(int p);
      for (int k = 0; k < D; k++) begin
         int j = (m_tail + k) % D;
         if (m_occ(j) && !m_disp[j] && in_class(p, j)) return j;
      end
      return -1;
   endfunction
   function automatic bit bus_find(int tag, output int val);
      for (int b = 0; b < NWB; b++) begin
         if (wb_vld[b] && int'(wb_tag[b*PW +: PW]) == tag) begin
            val = int'(wb_data[b*DW +: DW]);
            return 1;
         end
      end
      val = 0;
      return 0;
   endfunction
   function automatic bit producer_find(int tag, int self, output int val);
      for (int j = 0; j < D; j++) begin
         if (j != self && m_occ(j) && m_done[j] && m_pdst[j] == tag) begin
            val = m_imm[j];
            return 1;
         end
      end
      val = 0;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_head = 0; m_tail = 0; m_pend = 0; m_pidx = 0;
         for (int i = 0; i < D; i++) begin
            m_r1[i] = 0; m_r2[i] = 0; m_disp[i] = 0; m_done[i] = 0;
         end
      end else begin
         int pk[NP];
         bit w1[D], w2[D], wd[D];
         int x1[D], x2[D], xd[D];
         bit rt, fl;
         for (int p = 0; p < NP; p++) pk[p] = m_pick(p);
         rt = m_occ(m_tail) && m_done[m_tail];
         fl = m_full();
         for (int i = 0; i < D; i++) begin
            w1[i] = 0; w2[i] = 0; wd[i] = 0;
            x1[i] = 0; x2[i] = 0; xd[i] = 0;
            if (m_occ(i)) begin
               if (!m_r1[i]) begin
                  w1[i] = bus_find(m_s1[i], x1[i]);
                  if (!w1[i] && m_pend && m_pidx == i) w1[i] = producer_find(m_s1[i], i, x1[i]);
               end
               if (!m_r2[i]) begin
                  w2[i] = bus_find(m_s2[i], x2[i]);
                  if (!w2[i] && m_pend && m_pidx == i) w2[i] = producer_find(m_s2[i], i, x2[i]);
               end
               if (!m_done[i]) wd[i] = bus_find(m_pdst[i], xd[i]);
            end
         end
         for (int i = 0; i < D; i++) begin
            if (w1[i]) begin m_v1[i] = x1[i]; m_r1[i] = 1; end
            if (w2[i]) begin m_v2[i] = x2[i]; m_r2[i] = 1; end
            if (wd[i]) begin m_imm[i] = xd[i]; m_done[i] = 1; end
         end
         for (int p = 0; p < NP; p++) if (pk[p] >= 0 && dp_rdy[p]) m_disp[pk[p]] = 1;
         if (rt) m_tail = (m_tail + 1) % D;
         if (iss_valid && !fl) begin
            m_op[m_head] = int'(iss_op);       m_adst[m_head] = int'(iss_adst);
            m_pdst[m_head] = int'(iss_pdst);   m_s1[m_head] = int'(iss_src1);
            m_s2[m_head] = int'(iss_src2);     m_r1[m_head] = iss_src1_rdy;
            m_r2[m_head] = iss_src2_rdy;       m_v1[m_head] = int'(iss_src1_val);
            m_v2[m_head] = int'(iss_src2_val); m_imm[m_head] = int'(iss_imm);
            m_disp[m_head] = 0;                m_done[m_head] = 0;
            m_pidx = m_head;
            m_pend = 1;
            m_head = (m_head + 1) % D;
         end else begin
            m_pend = 0;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic check_outputs();
      string plab[NP] = '{"R3 R6 branch", "R4 R6 memory", "R5 R6 regop"};
      bit ert;
      chk("R2 iss_ready", int'(iss_ready), int'(!m_full()));
      for (int p = 0; p < NP; p++) begin
         int k = m_pick(p);
         chk({plab[p], " vld"}, int'(dp_vld[p]), int'(k >= 0));
         if (k >= 0 && dp_vld[p]) begin
            chk({plab[p], " idx"}, int'(dp_idx[p*IW +: IW]), k);
            chk({plab[p], " op"}, int'(dp_op[p*OPW +: OPW]), m_op[k]);
            chk({plab[p], " pdst"}, int'(dp_pdst[p*PW +: PW]), m_pdst[k]);
            chk("R7 R9 operand a", int'(dp_opa[p*DW +: DW]), m_v1[k]);
            chk("R7 R9 operand b", int'(dp_opb[p*DW +: DW]), m_v2[k]);
            chk("R8 imm", int'(dp_imm[p*DW +: DW]), m_imm[k]);
         end
      end
      ert = m_occ(m_tail) && m_done[m_tail];
      chk("R10 rt_vld", int'(rt_vld), int'(ert));
      if (ert && rt_vld) begin
         chk("R10 rt_adst", int'(rt_adst), m_adst[m_tail]);
         chk("R10 rt_pdst", int'(rt_pdst), m_pdst[m_tail]);
         chk("R8 R10 rt_data", int'(rt_data), m_imm[m_tail]);
      end
   endtask

   // mode 0: fill with ports stalled, 1: mixed, 2: drain
   task automatic drive_cycle(int mode);
      int chosen[NWB];
      int opts[6] = '{16, 8, 9, 1, 2, 3};
      wb_vld = '0;
      wb_tag = '0;
      wb_data = '0;
      for (int b = 0; b < NWB; b++) begin
         chosen[b] = -1;
         if (mode != 0 && ($urandom % 2) == 1) begin
            int st = int'($urandom % D);
            for (int k = 0; k < D; k++) begin
               int j = (st + k) % D;
               bit taken = 0;
               for (int c = 0; c < b; c++) if (chosen[c] == j) taken = 1;
               if (chosen[b] < 0 && !taken && m_occ(j) && m_disp[j] && !m_done[j]) chosen[b] = j;
            end
            if (chosen[b] >= 0) begin
               wb_vld[b] = 1'b1;
               wb_tag[b*PW +: PW] = PW'(m_pdst[chosen[b]]);
               wb_data[b*DW +: DW] = DW'($urandom);
            end
         end
      end
      // R7 bus priority: same tag on buses 0 and 1 with different data
      if (wb_vld[0] && ($urandom % 8) == 0) begin
         wb_vld[1] = 1'b1;
         wb_tag[PW +: PW] = wb_tag[0 +: PW];
         wb_data[DW +: DW] = wb_data[0 +: DW] ^ 16'h5a5a;
      end
      iss_valid = (mode == 0) ? 1'b1 : (mode == 2) ? 1'b0 : (($urandom % 10) < 7);
      iss_op = OPW'(opts[$urandom % 6]);
      iss_adst = AW'($urandom);
      iss_pdst = PW'(seq % 32);
      iss_imm = DW'($urandom);
      for (int s = 0; s < 2; s++) begin
         int tg = int'($urandom % 32);
         bit rd = 1;
         int r = int'($urandom % 4);
         if (r == 0 && wb_vld[0]) begin
            tg = int'(wb_tag[0 +: PW]); rd = 0;   // R9 race with writeback
         end else if (r == 1) begin
            for (int j = 0; j < D; j++)
               if (rd && m_occ(j) && !m_done[j]) begin tg = m_pdst[j]; rd = 0; end
         end
         if (s == 0) begin
            iss_src1 = PW'(tg); iss_src1_rdy = rd; iss_src1_val = DW'($urandom);
         end else begin
            iss_src2 = PW'(tg); iss_src2_rdy = rd; iss_src2_val = DW'($urandom);
         end
      end
      if (iss_valid && !m_full()) seq++;
      dp_rdy = (mode == 0) ? 3'b000 : (mode == 2) ? 3'b111 : NP'($urandom);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      iss_valid = 0; iss_op = '0; iss_adst = '0; iss_pdst = '0;
      iss_src1 = '0; iss_src1_rdy = 0; iss_src1_val = '0;
      iss_src2 = '0; iss_src2_rdy = 0; iss_src2_val = '0; iss_imm = '0;
      wb_vld = '0; wb_tag = '0; wb_data = '0; dp_rdy = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 iss_ready", int'(iss_ready), 1);
      chk("R1 dp_vld", int'(dp_vld), 0);
      chk("R1 rt_vld", int'(rt_vld), 0);
      for (int c = 0; c < 3200; c++) begin
         if (c > 0) @(negedge clk);
         check_outputs();
         drive_cycle(c < 14 ? 0 : (c < 3100 ? 1 : 2));
      end
      finish_run();
   end

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule